// File: doc/BRIEF.md
# Single-Cycle Next Program Address Unit

This block owns the program counter of a small 32-bit load/store processor that completes one instruction per clock. Every cycle it evaluates the branch condition that the decoder asks for, forms the candidate targets (sequential, branch-relative, absolute jump, register-indirect and the fixed trap entry), picks one with the PC-source select, and loads it into the PC on the next rising edge. It also returns the address of the following instruction, which the processor writes to the link register on calls.

All arithmetic is done on 30-bit word addresses. The two byte-select bits of every address the block produces are zero. The decoder, register file, ALU and instruction memory sit outside the block and drive its inputs combinationally.

Top module: `next_addr_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, `pc_q` becomes 0x00000000, whatever the other inputs are.
- R2: `pc_inc` always equals `pc_q` + 4, modulo 2^32.
- R3: With `pc_sel` = 0 and `br_kind` = 0 (no branch), `pc_next` equals `pc_q` + 4.
- R4: With `pc_sel` = 0 and `br_kind` = 1 (branch on equal), `pc_next` is `pc_q` + 4 + 4·offset when `rs_val` equals `rt_val`, and `pc_q` + 4 otherwise.
- R5: With `pc_sel` = 0 and `br_kind` = 2 (branch on not equal), `pc_next` is `pc_q` + 4 + 4·offset when `rs_val` differs from `rt_val`, and `pc_q` + 4 otherwise.
- R6: With `pc_sel` = 0 and `br_kind` = 3 (branch if negative), `pc_next` is `pc_q` + 4 + 4·offset when bit 31 of `rs_val` is 1, and `pc_q` + 4 otherwise. `rt_val` has no effect on this case.
- R7: `br_off` is a signed 16-bit word offset, and the sum wraps modulo 2^32 bytes (2^30 words). Negative offsets move backwards, and an increment past 0xFFFFFFFC gives 0.
- R8: With `pc_sel` = 1, `pc_next` = {`pc_q`[31:28], `jmp_field`[25:0], 2'b00}. The branch kind and the operands have no effect.
- R9: With `pc_sel` = 2, `pc_next` = {`rs_val`[31:2], 2'b00}. The low two bits of `rs_val` are ignored.
- R10: With `pc_sel` = 3, `pc_next` equals the parameter `SYS_ENTRY` (default 0x00000180) with its low two bits cleared.
- R11: When `rst_n` is high at a rising edge, `pc_q` takes the `pc_next` value present before that edge. Bits 1:0 of `pc_q` and `pc_next` are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rs_val | input | 32 | First source register value |
| rt_val | input | 32 | Second source register value |
| br_off | input | 16 | Signed branch offset in words |
| jmp_field | input | 26 | Absolute jump target field (word address bits) |
| br_kind | input | 2 | 0 none, 1 equal, 2 not equal, 3 negative |
| pc_sel | input | 2 | 0 sequential/branch, 1 jump field, 2 register, 3 trap entry |
| pc_q | output | 32 | Current program counter |
| pc_next | output | 32 | Address loaded at the next edge |
| pc_inc | output | 32 | Current PC plus 4 (link value) |

## Verification
A wrong condition decode, a bad sign extension or a misrouted select shows up at once on the combinational `pc_next` in the same cycle. One edge later it is also in `pc_q`, and from there it spreads into `pc_inc` and the jump target's upper bits. The bench therefore places the PC at chosen addresses, including the top of the address space and a non-zero upper nibble. At each one it sweeps every select and branch kind over operand pairs that are equal, unequal and negative, and over offsets at both signed extremes. It compares the outputs within the cycle and again after the edge.

// File: rtl/nau_pkg.sv
// Package: shared encodings for the next program address unit.
// Assumes: 2-bit codes driven by an external decoder.
package nau_pkg;

    typedef enum logic [1:0] {
        BK_NONE = 2'd0,
        BK_EQ   = 2'd1,
        BK_NE   = 2'd2,
        BK_NEG  = 2'd3
    } br_kind_e;

    typedef enum logic [1:0] {
        SRC_SEQ  = 2'd0,
        SRC_JUMP = 2'd1,
        SRC_REG  = 2'd2,
        SRC_TRAP = 2'd3
    } pc_src_e;

endpackage

// File: rtl/nau_cond.sv
// Module: nau_cond
// Decides whether the requested conditional branch is taken.
// Assumes: operands are full register values; kind comes from the decoder.
module nau_cond
    import nau_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  br_kind_e        kind,
    output logic            taken
);

    logic same;

    // Purpose: compare operands and pick the condition for this kind.
    always_comb begin
        same = (op_a == op_b);
        unique case (kind)
            BK_EQ:   taken = same;
            BK_NE:   taken = !same;
            BK_NEG:  taken = op_a[XLEN-1];
            default: taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/nau_targets.sv
// Module: nau_targets
// Forms the sequential, branch-relative and absolute-jump word targets.
// Assumes: word addresses; adders wrap modulo 2^AW.
module nau_targets #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16,
    parameter int JT_W  = 26
) (
    input  logic [XLEN-3:0]  pc_w,
    input  logic [OFF_W-1:0] off,
    input  logic [JT_W-1:0]  jt,
    output logic [XLEN-3:0]  inc_w,
    output logic [XLEN-3:0]  br_w,
    output logic [XLEN-3:0]  jmp_w
);

    localparam int AW   = XLEN - 2;
    localparam int EXT  = AW - OFF_W;
    localparam int HI_W = AW - JT_W;

    logic [AW-1:0] off_sx;

    // Purpose: sign-extend the offset and build the three candidate targets.
    always_comb begin
        off_sx = {{EXT{off[OFF_W-1]}}, off};
        inc_w  = pc_w + AW'(1);
        br_w   = inc_w + off_sx;
        jmp_w  = {pc_w[AW-1 -: HI_W], jt};
    end

endmodule

// File: rtl/nau_select.sv
// Module: nau_select
// Chooses the next word address among the four sources.
// Assumes: taken is valid only for the sequential source.
module nau_select
    import nau_pkg::*;
#(
    parameter int AW = 30
) (
    input  pc_src_e       sel,
    input  logic          taken,
    input  logic [AW-1:0] inc_w,
    input  logic [AW-1:0] br_w,
    input  logic [AW-1:0] jmp_w,
    input  logic [AW-1:0] reg_w,
    input  logic [AW-1:0] trap_w,
    output logic [AW-1:0] next_w
);

    // Purpose: four-way source multiplexer with branch override on the sequential path.
    always_comb begin
        unique case (sel)
            SRC_SEQ:  next_w = taken ? br_w : inc_w;
            SRC_JUMP: next_w = jmp_w;
            SRC_REG:  next_w = reg_w;
            default:  next_w = trap_w;
        endcase
    end

endmodule

// File: rtl/next_addr_unit.sv
// Module: next_addr_unit
// Holds the program counter and loads the selected next address each cycle.
// Assumes: synchronous active-low reset to address zero; byte bits kept at 00.
module next_addr_unit
    import nau_pkg::*;
#(
    parameter int          XLEN      = 32,
    parameter int          OFF_W     = 16,
    parameter int          JT_W      = 26,
    parameter logic [31:0] SYS_ENTRY = 32'h0000_0180
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [XLEN-1:0]  rs_val,
    input  logic [XLEN-1:0]  rt_val,
    input  logic [OFF_W-1:0] br_off,
    input  logic [JT_W-1:0]  jmp_field,
    input  logic [1:0]       br_kind,
    input  logic [1:0]       pc_sel,
    output logic [XLEN-1:0]  pc_q,
    output logic [XLEN-1:0]  pc_next,
    output logic [XLEN-1:0]  pc_inc
);

    localparam int            AW     = XLEN - 2;
    localparam logic [AW-1:0] TRAP_W = SYS_ENTRY[XLEN-1:2];

    logic [AW-1:0] pc_w_q;
    logic [AW-1:0] inc_w, br_w, jmp_w, next_w;
    logic          taken;

    nau_cond #(.XLEN(XLEN)) cond_i (
        .op_a  (rs_val),
        .op_b  (rt_val),
        .kind  (br_kind_e'(br_kind)),
        .taken (taken)
    );

    nau_targets #(.XLEN(XLEN), .OFF_W(OFF_W), .JT_W(JT_W)) tgt_i (
        .pc_w  (pc_w_q),
        .off   (br_off),
        .jt    (jmp_field),
        .inc_w (inc_w),
        .br_w  (br_w),
        .jmp_w (jmp_w)
    );

    nau_select #(.AW(AW)) sel_i (
        .sel    (pc_src_e'(pc_sel)),
        .taken  (taken),
        .inc_w  (inc_w),
        .br_w   (br_w),
        .jmp_w  (jmp_w),
        .reg_w  (rs_val[XLEN-1:2]),
        .trap_w (TRAP_W),
        .next_w (next_w)
    );

    // Purpose: program counter register, word address only.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_w_q <= '0;
        else        pc_w_q <= next_w;
    end

    // Purpose: expand word addresses back to byte addresses.
    always_comb begin
        pc_q    = {pc_w_q, 2'b00};
        pc_inc  = {inc_w, 2'b00};
        pc_next = {next_w, 2'b00};
    end

    AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> pc_q == '0); // R1
    AST_PC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> pc_q == $past(pc_next)); // R11
    AST_SEQ_NO_BRANCH: assert property (@(posedge clk) disable iff (!rst_n) (pc_sel == SRC_SEQ && br_kind == BK_NONE) |-> pc_next == pc_inc); // R3
    AST_JUMP_KEEPS_TOP: assert property (@(posedge clk) disable iff (!rst_n) pc_sel == SRC_JUMP |-> (pc_next[XLEN-1:XLEN-4] == pc_q[XLEN-1:XLEN-4] && pc_next[JT_W+1:2] == jmp_field)); // R8
    AST_REG_TARGET: assert property (@(posedge clk) disable iff (!rst_n) pc_sel == SRC_REG |-> pc_next[XLEN-1:2] == rs_val[XLEN-1:2]); // R9
    AST_TRAP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) pc_sel == SRC_TRAP |-> pc_next[XLEN-1:2] == TRAP_W); // R10
    AST_NEG_IGNORES_RT: assert property (@(posedge clk) disable iff (!rst_n) (pc_sel == SRC_SEQ && br_kind == BK_NEG && !rs_val[XLEN-1]) |-> pc_next == pc_inc); // R6

endmodule

// File: tb/next_addr_unit_tb_top.sv
// Bench: sweeps PC positions, selects, branch kinds, operand pairs and offsets.
module next_addr_unit_tb_top;

    localparam logic [31:0] SYS = 32'h0000_0180;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] rs_val = '0, rt_val = '0;
    logic [15:0] br_off = '0;
    logic [25:0] jmp_field = '0;
    logic [1:0]  br_kind = '0, pc_sel = '0;
    logic [31:0] pc_q, pc_next, pc_inc;

    int checks = 0;
    int errors = 0;

    next_addr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .rs_val(rs_val), .rt_val(rt_val),
        .br_off(br_off), .jmp_field(jmp_field), .br_kind(br_kind),
        .pc_sel(pc_sel), .pc_q(pc_q), .pc_next(pc_next), .pc_inc(pc_inc)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [31:0] pc, input logic [31:0] rs,
                                          input logic [31:0] rt, input logic [15:0] off,
                                          input logic [25:0] jt, input logic [1:0] kind,
                                          input logic [1:0] sel);
        logic [31:0] seq, tgt;
        logic        go;
        seq = pc + 32'd4;
        tgt = seq + ({{16{off[15]}}, off} << 2);
        case (kind)
            2'd1:    go = (rs == rt);
            2'd2:    go = (rs != rt);
            2'd3:    go = rs[31];
            default: go = 1'b0;
        endcase
        case (sel)
            2'd0:    return go ? tgt : seq;
            2'd1:    return {pc[31:28], jt, 2'b00};
            2'd2:    return {rs[31:2], 2'b00};
            default: return {SYS[31:2], 2'b00};
        endcase
    endfunction

    // Places the PC at an address through the register source.
    task automatic set_pc(input logic [31:0] v);
        @(negedge clk);
        pc_sel = 2'd2; rs_val = v; br_kind = 2'd0;
        @(posedge clk); #1;
    endtask

    task automatic trial(input logic [31:0] rs, input logic [31:0] rt, input logic [15:0] off,
                         input logic [25:0] jt, input logic [1:0] kind, input logic [1:0] sel,
                         input string tag);
        logic [31:0] pc0, exp;
        @(negedge clk);
        pc0 = pc_q;
        rs_val = rs; rt_val = rt; br_off = off; jmp_field = jt; br_kind = kind; pc_sel = sel;
        exp = model(pc0, rs, rt, off, jt, kind, sel);
        #5;
        check(tag, pc_next, exp);
        check("R2", pc_inc, pc0 + 32'd4);
        @(posedge clk); #1;
        check("R11", pc_q, exp);
    endtask

    initial begin
        logic [31:0] pcs [6];
        logic [15:0] offs [6];
        logic [31:0] ra [4], rb [4];
        string tg;
        pcs[0] = 32'h0000_0000; pcs[1] = 32'h0000_0004; pcs[2] = 32'h0000_1000;
        pcs[3] = 32'h7FFF_FFFC; pcs[4] = 32'hFFFF_FFFC; pcs[5] = 32'hF000_0040;
        offs[0] = 16'h0000; offs[1] = 16'h0001; offs[2] = 16'hFFFF;
        offs[3] = 16'h7FFF; offs[4] = 16'h8000; offs[5] = 16'h0005;
        ra[0] = 32'h0000_1234; rb[0] = 32'h0000_1234;
        ra[1] = 32'h0000_1234; rb[1] = 32'h0000_1235;
        ra[2] = 32'h8000_0010; rb[2] = 32'h8000_0010;
        ra[3] = 32'hFFFF_FFFF; rb[3] = 32'h0000_0000;

        // R1: reset holds PC at zero despite a register jump request.
        pc_sel = 2'd2; rs_val = 32'h0000_1234;
        repeat (2) @(posedge clk);
        #1 check("R1", pc_q, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1 check("R9", pc_q, 32'h0000_1234);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1 check("R1", pc_q, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // R9 and R11: low bits of the register target are dropped.
        trial(32'hABCD_0003, 32'h0, 16'h0, 26'h0, 2'd1, 2'd2, "R9");
        check("R11", {30'h0, pc_q[1:0]}, 32'h0);

        // R7: wrap past the top of the address space, and a backward branch below zero.
        set_pc(32'hFFFF_FFFC);
        trial(32'h0, 32'h1, 16'h0, 26'h0, 2'd0, 2'd0, "R7");
        trial(32'h5, 32'h5, 16'hFFFE, 26'h0, 2'd1, 2'd0, "R7");
        check("R7", pc_q, 32'hFFFF_FFFC);

        // Full sweep of every select and branch kind.
        for (int p = 0; p < 6; p++)
            for (int o = 0; o < 6; o++)
                for (int k = 0; k < 4; k++)
                    for (int q = 0; q < 4; q++)
                        for (int s = 0; s < 4; s++) begin
                            set_pc(pcs[p]);
                            case (s)
                                1: tg = "R8";
                                2: tg = "R9";
                                3: tg = "R10";
                                default: tg = (k == 0) ? "R3" : (k == 1) ? "R4" : (k == 2) ? "R5" : "R6";
                            endcase
                            if (s == 0 && offs[o][15] && k != 0) tg = {tg, "/R7"};
                            trial(ra[q], rb[q], offs[o], 26'h2AB_CDEF ^ 26'(p * 7 + o), 2'(k), 2'(s), tg);
                        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule